// File: doc/BRIEF.md
# Clock Source and Prescale Controller

This block manages the clocks of a small microcontroller. Everything runs in one system clock domain, which stands for the crystal-derived clock, and the block produces two enables in that domain. The internal-clock enable runs at the full rate, at half rate, or at a low-power divide-by-16 rate. It can also follow the rising edges of an alternate clock input, but only while that input is seen toggling. The CPU-clock enable is the internal-clock enable thinned by a 3-bit prescaler.

The block also handles three requests:
- A wait-for-interrupt request stops the CPU clock. If low-power wait is enabled, it also slows the internal clock. Any interrupt request ends the wait.
- A halt request either switches the clock unit off or raises a one-cycle reset request.
- A regulator-off setting forces the PLL request off.

Software reaches four byte-wide registers through a simple write strobe with a combinational read port. Address 0 is mode, 1 is control, 2 is regulator and 3 is status (read-only).

Top module: `clk_src_top`

## Requirements
- R1: Mode bits 4:2 hold a prescale value N. `cpuClkEn` pulses once for every N+1 `intClkEn` pulses, and on every `intClkEn` pulse when N is 0.
- R2: Mode bit 5 set makes `intClkEn` pulse on every second clock, and clear makes it pulse on every clock. Mode resets to E0h, and bits 7:6 are plain storage bits.
- R3: Control bit 2 requests the alternate clock. The switch happens only while the alternate clock is present. Status bit 0 reports the switch. While it is switched, `intClkEn` pulses once per rising edge of `altClk`.
- R4: A `wfiReq` pulse with control bit 0 clear enters wait. In wait `cpuClkEn` stays low and `intClkEn` keeps its rate.
- R5: `irqOut` high ends wait at the next clock edge. Status bit 2 shows wait. A `wfiReq` that arrives in the same cycle as an interrupt does not enter wait.
- R6: In wait with control bit 0 set, `intClkEn` pulses once per 16 clocks when control bit 1 is clear. When bit 1 is set and the alternate clock is present, control bit 2 is set and the alternate clock drives `intClkEn`.
- R7: If the alternate clock was taken during low-power wait, it stays selected after the wait ends, with control bit 2 still set. Clearing control bit 2 returns the block to the crystal clock.
- R8: A `haltReq` pulse with control bit 3 clear raises `clockOff` and stops both enables until reset. With control bit 3 set it pulses `resetReq` for one cycle on the next clock instead, and the clocks keep running.
- R9: Regulator register bit 3 drives `regOff`, and bit 0 is the PLL request behind `pllOn`. Setting bit 3 clears bit 0 and drops `pllOn`, and clearing bit 3 later does not restore it. The register resets to 00h.
- R10: Control bit 7 clear routes `irqExt` to `irqOut`, and set routes `irqInt`. The register resets to 00h.
- R11: Status bit 1 shows the alternate clock present. It is updated at the end of each 16-clock window: set if a synchronised rising edge was seen in that window, cleared if none was. When it clears, a committed switch falls back to the crystal clock.
- R12: Reserved bits read 0 and ignore writes: mode bits 1:0, control bits 6:4, and regulator bits 7:4, 2 and 1. Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (crystal-derived) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 mode, 1 control, 2 regulator, 3 status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| altClk | input | 1 | Alternate clock, asynchronous |
| wfiReq | input | 1 | Wait-for-interrupt request pulse |
| haltReq | input | 1 | Halt request pulse |
| irqExt | input | 1 | External interrupt input |
| irqInt | input | 1 | Internal clock-unit interrupt |
| intClkEn | output | 1 | Internal clock enable |
| cpuClkEn | output | 1 | Prescaled CPU clock enable |
| irqOut | output | 1 | Selected interrupt request |
| resetReq | output | 1 | One-cycle reset request from halt |
| clockOff | output | 1 | Oscillator, PLL and clock unit switched off |
| pllOn | output | 1 | PLL selected |
| regOff | output | 1 | Main regulator reported off |

## Verification
A wait-for-interrupt request and an interrupt pulse can land in the same cycle. The bench drives `wfiReq` and `irqExt` high together for one clock, then reads status bit 2 on the following cycle. The interrupt must win, so the block must not be in wait.

A second overlap comes from the alternate-clock capture during low-power wait. There, the hardware sets control bit 2 while the wait is still active. The bench judges it by the value read back after the interrupt ends the wait, and by the continued alternate-clock rate.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int PRS_W = 3;
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_REGU = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic             div2;
    logic [PRS_W-1:0] prs;
    logic             useAlt;
    logic             slowWait;
    logic             cpuStop;
    logic             unitOff;
  } clkStrobe_t;
endpackage

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       wfiReq,
  input  logic       haltReq,
  input  logic       irqExt,
  input  logic       irqInt,
  input  logic       altPresent,
  output clkStrobe_t strobe,
  output logic       irqOut,
  output logic       resetReq,
  output logic       clockOff,
  output logic       pllOn,
  output logic       regOff
);
  logic [1:0]       modeSpare;
  logic             div2Q;
  logic [PRS_W-1:0] prsQ;
  logic irqSelQ, swRstEnQ, altReqQ, waitAltQ, lpWaitQ;
  logic regOffQ, pllReqQ;
  logic inWaitQ, haltedQ, resetReqQ, altActiveQ;
  logic wrMode, wrCtrl, wrRegu, lpAltGrab;

  assign wrMode = wrEn && (addr == ADDR_MODE);
  assign wrCtrl = wrEn && (addr == ADDR_CTRL);
  assign wrRegu = wrEn && (addr == ADDR_REGU);
  assign irqOut = irqSelQ ? irqInt : irqExt;
  // low-power wait grabs the alternate clock when it is there
  assign lpAltGrab = inWaitQ && lpWaitQ && waitAltQ && altPresent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSpare <= 2'b11;
      div2Q     <= 1'b1;
      prsQ      <= '0;
    end else if (wrMode) begin
      modeSpare <= wrData[7:6];
      div2Q     <= wrData[5];
      prsQ      <= wrData[4:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqSelQ  <= 1'b0;
      swRstEnQ <= 1'b0;
      altReqQ  <= 1'b0;
      waitAltQ <= 1'b0;
      lpWaitQ  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        irqSelQ  <= wrData[7];
        swRstEnQ <= wrData[3];
        altReqQ  <= wrData[2];
        waitAltQ <= wrData[1];
        lpWaitQ  <= wrData[0];
      end
      if (lpAltGrab) altReqQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regOffQ <= 1'b0;
      pllReqQ <= 1'b0;
    end else if (wrRegu) begin
      regOffQ <= wrData[3];
      pllReqQ <= wrData[0] & ~wrData[3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWaitQ    <= 1'b0;
      haltedQ    <= 1'b0;
      resetReqQ  <= 1'b0;
      altActiveQ <= 1'b0;
    end else begin
      if (haltedQ)     inWaitQ <= 1'b0;
      else if (irqOut) inWaitQ <= 1'b0;
      else if (wfiReq) inWaitQ <= 1'b1;
      resetReqQ <= haltReq && swRstEnQ && !haltedQ;
      if (haltReq && !swRstEnQ) haltedQ <= 1'b1;
      altActiveQ <= altReqQ && altPresent && !haltedQ;
    end
  end

  always_comb begin
    case (addr)
      ADDR_MODE: rdData = {modeSpare, div2Q, prsQ, 2'b00};
      ADDR_CTRL: rdData = {irqSelQ, 3'b000, swRstEnQ, altReqQ, waitAltQ, lpWaitQ};
      ADDR_REGU: rdData = {4'b0000, regOffQ, 2'b00, pllReqQ};
      default:   rdData = {5'b00000, inWaitQ, altPresent, altActiveQ};
    endcase
  end

  assign strobe.div2     = div2Q;
  assign strobe.prs      = prsQ;
  assign strobe.useAlt   = altActiveQ;
  assign strobe.slowWait = inWaitQ && lpWaitQ && !altActiveQ;
  assign strobe.cpuStop  = inWaitQ;
  assign strobe.unitOff  = haltedQ;
  assign resetReq = resetReqQ;
  assign clockOff = haltedQ;
  assign pllOn    = pllReqQ && !regOffQ && !haltedQ;
  assign regOff   = regOffQ;

  assert_alt_needs_presence_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(altActiveQ) |-> $past(altPresent));
  assert_wait_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inWaitQ && irqOut) |=> !inWaitQ);
  assert_halt_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReqQ |-> ($past(swRstEnQ) && !haltedQ));
  assert_pll_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    regOffQ |-> !pllReqQ);
endmodule

// File: rtl/clk_src_datapath.sv
module clk_src_datapath
  import clk_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LEN     = 16,
  parameter int SLOW_DIV    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       altClk,
  input  clkStrobe_t strobe,
  output logic       altPresent,
  output logic       intTick,
  output logic       cpuTick
);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int SLOW_W = $clog2(SLOW_DIV);

  logic [SYNC_STAGES:0] syncQ;
  logic altEdge;

  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= altClk;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
      end
    end
  endgenerate

  // rising edge of the synchronised alternate clock
  assign altEdge = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];

  logic [WIN_W-1:0] winCnt;
  logic sawEdge, presentQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt   <= '0;
      sawEdge  <= 1'b0;
      presentQ <= 1'b0;
    end else if (winCnt == WIN_W'(WIN_LEN-1)) begin
      winCnt   <= '0;
      presentQ <= sawEdge || altEdge;
      sawEdge  <= 1'b0;
    end else begin
      winCnt <= winCnt + 1'b1;
      if (altEdge) sawEdge <= 1'b1;
    end
  end
  assign altPresent = presentQ;

  logic phaseQ;
  logic [SLOW_W-1:0] slowCnt;
  logic normalTick, slowTick;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      slowCnt <= '0;
    end else if (!strobe.unitOff) begin
      phaseQ  <= !phaseQ;
      slowCnt <= (slowCnt == SLOW_W'(SLOW_DIV-1)) ? '0 : slowCnt + 1'b1;
    end
  end
  assign normalTick = strobe.div2 ? phaseQ : 1'b1;
  assign slowTick   = (slowCnt == SLOW_W'(SLOW_DIV-1));

  always_comb begin
    if (strobe.unitOff)       intTick = 1'b0;
    else if (strobe.slowWait) intTick = slowTick;
    else if (strobe.useAlt)   intTick = altEdge;
    else                      intTick = normalTick;
  end

  logic [PRS_W-1:0] presCnt;
  logic presHit;
  assign presHit = (presCnt >= strobe.prs);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presCnt <= '0;
    else if (intTick) presCnt <= presHit ? '0 : presCnt + 1'b1;
  end
  assign cpuTick = intTick && presHit && !strobe.cpuStop;

  assert_prescale_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTick && strobe.prs != 0) |=> (!cpuTick || strobe.prs == 0));
  assert_div2_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (intTick && strobe.div2 && !strobe.useAlt && !strobe.slowWait)
      |=> (!intTick || !strobe.div2 || strobe.useAlt || strobe.slowWait));
  assert_slow_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intTick && strobe.slowWait) |=> (!intTick || !strobe.slowWait));
  assert_present_needs_edge_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(presentQ) |-> $past(sawEdge || altEdge));
endmodule

// File: rtl/clk_src_top.sv
module clk_src_top
  import clk_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LEN     = 16,
  parameter int SLOW_DIV    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       altClk,
  input  logic       wfiReq,
  input  logic       haltReq,
  input  logic       irqExt,
  input  logic       irqInt,
  output logic       intClkEn,
  output logic       cpuClkEn,
  output logic       irqOut,
  output logic       resetReq,
  output logic       clockOff,
  output logic       pllOn,
  output logic       regOff
);
  clkStrobe_t strobe;
  logic altPresent;

  clk_src_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .wfiReq(wfiReq), .haltReq(haltReq), .irqExt(irqExt),
    .irqInt(irqInt), .altPresent(altPresent), .strobe(strobe), .irqOut(irqOut),
    .resetReq(resetReq), .clockOff(clockOff), .pllOn(pllOn), .regOff(regOff)
  );

  clk_src_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .WIN_LEN(WIN_LEN), .SLOW_DIV(SLOW_DIV)
  ) uPath (
    .clk(clk), .rstN(rstN), .altClk(altClk), .strobe(strobe),
    .altPresent(altPresent), .intTick(intClkEn), .cpuTick(cpuClkEn)
  );
endmodule

// File: tb/tb_clk_src_top.sv
module tb_clk_src_top;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0, rdData;
  logic altClk = 1'b0, altOn = 1'b0;
  logic wfiReq = 1'b0, haltReq = 1'b0, irqExt = 1'b0, irqInt = 1'b0;
  logic intClkEn, cpuClkEn, irqOut, resetReq, clockOff, pllOn, regOff;

  int checks = 0, errors = 0;
  int expQ[$], actQ[$];
  string tagQ[$];
  bit done = 0;

  clk_src_top dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  // alternate clock: 120 ns period, edges clear of system edges
  initial begin
    #7;
    forever begin
      #60;
      if (altOn) altClk = ~altClk;
    end
  end

  // monitor: pops expected items and compares with observed results
  initial forever begin
    @(posedge clk);
    while (actQ.size() > 0 && expQ.size() > 0) begin
      automatic int a = actQ.pop_front();
      automatic int e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual %0d expected %0d", t, a, e);
      end
    end
  end

  task automatic expectVal(string tag, int e);
    tagQ.push_back(tag);
    expQ.push_back(e);
  endtask

  task automatic check(string tag, int a, int e);
    expectVal(tag, e);
    actQ.push_back(a);
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output int d);
    @(negedge clk);
    addr = a;
    #5;
    d = int'(rdData);
  endtask

  task automatic countTicks(int n, output int ci, output int cc);
    ci = 0; cc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #5;
      ci += int'(intClkEn);
      cc += int'(cpuClkEn);
    end
  endtask

  task automatic pulseWfi();
    @(negedge clk); wfiReq = 1'b1;
    @(negedge clk); wfiReq = 1'b0;
  endtask

  task automatic pulseIrq();
    @(negedge clk); irqExt = 1'b1;
    @(negedge clk); irqExt = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, ci, cc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rdReg(2'd0, v); check("R2 mode reset", v, 8'hE0);
    rdReg(2'd1, v); check("R10 ctrl reset", v, 0);
    rdReg(2'd2, v); check("R9 regu reset", v, 0);
    rdReg(2'd3, v); check("R12 status reset", v, 0);

    // R2: default halving
    countTicks(32, ci, cc);
    countTicks(64, ci, cc);
    check("R2 div2 int", ci, 32); check("R1 div2 cpu", cc, 32);
    wrReg(2'd0, 8'h00); idle(16);
    countTicks(64, ci, cc);
    check("R2 full int", ci, 64); check("R1 prs0 cpu", cc, 64);
    wrReg(2'd0, 8'h0C); idle(16);
    countTicks(64, ci, cc);
    check("R1 prs3 cpu", cc, 16);
    wrReg(2'd0, 8'h3C); idle(32);
    countTicks(128, ci, cc);
    check("R2 div2 prs7 int", ci, 64); check("R1 prs7 cpu", cc, 8);

    // R12: reserved mode bits
    wrReg(2'd0, 8'hFF); rdReg(2'd0, v); check("R12 mode reserved", v, 8'hFC);
    wrReg(2'd0, 8'h00);

    // R10: interrupt source select
    @(negedge clk); irqExt = 1'b1; #5; check("R10 ext routed", int'(irqOut), 1);
    @(negedge clk); irqExt = 1'b0;
    wrReg(2'd1, 8'h80);
    @(negedge clk); irqExt = 1'b1; #5; check("R10 ext blocked", int'(irqOut), 0);
    @(negedge clk); irqExt = 1'b0; irqInt = 1'b1; #5; check("R10 int routed", int'(irqOut), 1);
    @(negedge clk); irqInt = 1'b0;
    wrReg(2'd1, 8'h00);

    // R3: request while alternate clock absent
    wrReg(2'd1, 8'h04); idle(40);
    rdReg(2'd3, v); check("R3 no switch when absent", v, 0);
    countTicks(64, ci, cc); check("R3 crystal kept", ci, 64);

    // R11/R3: alternate clock appears
    altOn = 1'b1; idle(48);
    rdReg(2'd3, v); check("R11 present and R3 switched", v, 3);
    countTicks(120, ci, cc);
    check("R3 alt int rate", ci, 20); check("R3 alt cpu rate", cc, 20);
    altOn = 1'b0; idle(48);
    rdReg(2'd3, v); check("R11 absent", v, 0);
    countTicks(64, ci, cc); check("R11 fallback rate", ci, 64);
    wrReg(2'd1, 8'h00);

    // R4/R5: normal wait
    pulseWfi();
    rdReg(2'd3, v); check("R5 wait flag", v, 4);
    countTicks(32, ci, cc);
    check("R4 int unchanged", ci, 32); check("R4 cpu stopped", cc, 0);
    pulseIrq();
    rdReg(2'd3, v); check("R5 wait ended", v, 0);
    countTicks(32, ci, cc); check("R5 cpu resumed", cc, 32);

    // R5: wait request and interrupt in the same cycle
    @(negedge clk); wfiReq = 1'b1; irqExt = 1'b1;
    @(negedge clk); wfiReq = 1'b0; irqExt = 1'b0;
    rdReg(2'd3, v); check("R5 collision no wait", v, 0);

    // R6: low-power wait at divide-by-16
    wrReg(2'd1, 8'h01);
    pulseWfi(); idle(16);
    countTicks(64, ci, cc);
    check("R6 slow int", ci, 4); check("R6 slow cpu", cc, 0);
    pulseIrq();
    rdReg(2'd3, v); check("R6 slow exit", v, 0);

    // R6/R7: low-power wait on the alternate clock
    altOn = 1'b1; idle(48);
    wrReg(2'd1, 8'h03);
    pulseWfi(); idle(16);
    rdReg(2'd1, v); check("R6 select bit set", v, 8'h07);
    rdReg(2'd3, v); check("R6 alt in wait status", v, 7);
    countTicks(120, ci, cc);
    check("R6 alt int rate", ci, 20); check("R6 alt cpu stopped", cc, 0);
    pulseIrq();
    rdReg(2'd3, v); check("R7 alt kept", v, 3);
    rdReg(2'd1, v); check("R7 select kept", v, 8'h07);
    countTicks(120, ci, cc); check("R7 alt cpu rate", cc, 20);
    wrReg(2'd1, 8'h00); idle(2);
    rdReg(2'd3, v); check("R7 back to crystal", v, 2);
    countTicks(64, ci, cc); check("R7 crystal rate", ci, 64);
    altOn = 1'b0; idle(48);

    // R9: regulator and PLL
    wrReg(2'd2, 8'h01); #5;
    check("R9 pll on", int'(pllOn), 1);
    wrReg(2'd2, 8'h09);
    rdReg(2'd2, v); check("R9 pll cleared", v, 8'h08);
    check("R9 regOff", int'(regOff), 1); check("R9 pll off", int'(pllOn), 0);
    wrReg(2'd2, 8'hFF);
    rdReg(2'd2, v); check("R12 regu reserved", v, 8'h08);
    wrReg(2'd2, 8'h00); #5;
    check("R9 pll stays off", int'(pllOn), 0);

    // R12: status is read-only, ctrl reserved bits
    wrReg(2'd3, 8'hFF);
    rdReg(2'd3, v); check("R12 status read-only", v, 0);
    wrReg(2'd1, 8'h70);
    rdReg(2'd1, v); check("R12 ctrl reserved", v, 0);

    // R8: halt with reset enable
    wrReg(2'd1, 8'h08);
    @(negedge clk); haltReq = 1'b1;
    @(negedge clk); haltReq = 1'b0; #5;
    check("R8 reset pulse", int'(resetReq), 1);
    @(negedge clk); #5;
    check("R8 reset one cycle", int'(resetReq), 0);
    check("R8 clocks kept", int'(clockOff), 0);
    countTicks(32, ci, cc); check("R8 running", ci, 32);

    // R8: halt switches the unit off
    wrReg(2'd1, 8'h00);
    @(negedge clk); haltReq = 1'b1;
    @(negedge clk); haltReq = 1'b0; #5;
    check("R8 clockOff", int'(clockOff), 1);
    check("R8 no reset", int'(resetReq), 0);
    countTicks(32, ci, cc);
    check("R8 int stopped", ci, 0); check("R8 cpu stopped", cc, 0);
    @(negedge clk); rstN = 1'b0; #5;
    check("R8 cleared by reset", int'(clockOff), 0);
    @(negedge clk); rstN = 1'b1;

    done = 1;
    finishRun();
  end
endmodule